// File: doc/BRIEF.md
# Quadword Access Instruction Doubler

This decode-stage sequencer turns each 16-byte memory instruction (quadword load, quadword store, load-reserve and store-conditional) into two doubleword micro-ops that are issued on successive handshakes. Such an instruction names an even/odd register pair. The block chooses the register number for each op from the current endianness. It marks both ops as part of a repeated pair and flags which one is the second. It steps the effective address by one doubleword for the second op. It also reports illegal register overlaps and misaligned little-endian loads. Any other instruction passes through as a single op.

Both sides use valid/busy handshakes. Upstream sees `in_busy` and holds its instruction while it is high. Downstream drives `out_busy` to stall the op currently on display.

The controller is a four-state machine:
- `ST_EMPTY`: nothing is held.
- `ST_SINGLE`: a plain op is shown.
- `ST_FIRST`: the first half of a pair is shown.
- `ST_SECOND`: the second half is shown.

Transitions:
- accept: `ST_EMPTY` goes to `ST_FIRST` or `ST_SINGLE`.
- advance: `ST_FIRST` goes to `ST_SECOND` once downstream is not busy.
- retire: `ST_SINGLE` or `ST_SECOND` goes to `ST_EMPTY` once downstream is not busy and no new instruction is waiting.
- chain: `ST_SINGLE` or `ST_SECOND` goes straight to `ST_FIRST` or `ST_SINGLE` when a new instruction is accepted in the same cycle.

Top module: `qd_doubler`

## Requirements
- R1: An instruction whose kind code is 1 (quad load), 2 (quad store), 3 (load-reserve) or 4 (store-conditional) produces exactly two ops. Any other kind code produces one op that carries the target register unchanged, the address unchanged, and repeat and second both low.
- R2: When `in_big_endian` is 0, the first op carries the target register with bit 0 set to 1, and the second op carries it with bit 0 cleared.
- R3: When `in_big_endian` is 1, the first op carries the target register with bit 0 cleared, and the second op carries it with bit 0 set.
- R4: `out_repeat` is high on both ops of a pair. `out_second` is high only on the second op.
- R5: The first op carries the instruction's address, and the second op carries that address plus 8.
- R6: A quad load (kind 1) whose base register equals its target register raises `out_illegal` on both ops.
- R7: A load-reserve (kind 3) whose base or index register equals its target register raises `out_illegal`. Store kinds never raise it.
- R8: A little-endian quad load or load-reserve whose address has any of bits 3..0 set raises `out_align_fault`. Stores and big-endian accesses never raise it.
- R9: `out_irq_hold` is high exactly while the second op of a pair is shown, so no asynchronous or trace interrupt is taken between the two halves.
- R10: `in_busy` stays high while a first op is shown. While `out_busy` is high, the shown op's register, address and flags do not change.
- R11: After reset, `out_valid` and `in_busy` are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream instruction present |
| in_busy | output | 1 | Upstream must hold its instruction |
| in_kind | input | 3 | Instruction kind code |
| in_big_endian | input | 1 | Current endianness, 1 = big-endian |
| in_rt | input | REG_W | Target/source register pair number |
| in_ra | input | REG_W | Base register number |
| in_rb | input | REG_W | Index register number |
| in_ea | input | ADDR_W | Effective address of the 16-byte operand |
| out_valid | output | 1 | Op presented downstream |
| out_busy | input | 1 | Downstream stall |
| out_reg | output | REG_W | Register number for this op |
| out_addr | output | ADDR_W | Doubleword address for this op |
| out_repeat | output | 1 | Op is half of a pair |
| out_second | output | 1 | Op is the second half |
| out_irq_hold | output | 1 | Interrupts must be deferred |
| out_illegal | output | 1 | Illegal register overlap |
| out_align_fault | output | 1 | Alignment exception required |

## Verification
An instruction accepted at one rising edge shows its first op from that edge onward, so the bench samples it at the next falling edge. When downstream is not busy, the second op follows one edge later, and the outputs drop back to idle on the edge after that. The bench therefore waits exactly one falling edge between these samples and compares the register, address and flags against hand-computed values. Under a stall, the first op is sampled at several successive falling edges to confirm that it stays frozen, and the second op is checked one edge after the stall is released.

// File: rtl/qd_pkg.sv
`timescale 1ns/1ps
package qd_pkg;

    typedef enum logic [2:0] {
        QK_PLAIN     = 3'd0,
        QK_LOAD      = 3'd1,
        QK_STORE     = 3'd2,
        QK_LOAD_RSV  = 3'd3,
        QK_STORE_CND = 3'd4
    } qkind_e;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_SINGLE = 2'd1,
        ST_FIRST  = 2'd2,
        ST_SECOND = 2'd3
    } qstate_e;

    function automatic logic kind_is_pair(input logic [2:0] k);
        return (k == QK_LOAD) || (k == QK_STORE) ||
               (k == QK_LOAD_RSV) || (k == QK_STORE_CND);
    endfunction

endpackage

// File: rtl/qd_regsel.sv
`timescale 1ns/1ps
module qd_regsel #(
    parameter int REG_W = 5
) (
    input  logic             is_pair,
    input  logic             big_endian,
    input  logic             second,
    input  logic [REG_W-1:0] rt,
    output logic [REG_W-1:0] reg_out
);
    // odd register goes first in little-endian, last in big-endian
    logic want_odd;

    always_comb begin
        want_odd = big_endian ? second : !second;
        if (is_pair) begin
            reg_out = {rt[REG_W-1:1], want_odd};
        end else begin
            reg_out = rt;
        end
    end
endmodule

// File: rtl/qd_addrstep.sv
`timescale 1ns/1ps
module qd_addrstep #(
    parameter int ADDR_W   = 64,
    parameter int DW_BYTES = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              second,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DW_BYTES);

    always_comb begin
        addr = second ? (base + STEP) : base;
    end
endmodule

// File: rtl/qd_legality.sv
`timescale 1ns/1ps
module qd_legality
    import qd_pkg::*;
#(
    parameter int REG_W      = 5,
    parameter int QW_BYTES   = 16,
    parameter int ALIGN_BITS = $clog2(QW_BYTES)
) (
    input  logic [2:0]            kind,
    input  logic                  big_endian,
    input  logic [REG_W-1:0]      rt,
    input  logic [REG_W-1:0]      ra,
    input  logic [REG_W-1:0]      rb,
    input  logic [ALIGN_BITS-1:0] ea_lo,
    output logic                  illegal,
    output logic                  align_fault
);
    logic is_load;

    always_comb begin
        is_load     = (kind == QK_LOAD) || (kind == QK_LOAD_RSV);
        illegal     = ((kind == QK_LOAD) && (ra == rt)) ||
                      ((kind == QK_LOAD_RSV) && ((ra == rt) || (rb == rt)));
        align_fault = is_load && !big_endian && (ea_lo != '0);
    end
endmodule

// File: rtl/qd_doubler.sv
`timescale 1ns/1ps
module qd_doubler
    import qd_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int ADDR_W   = 64,
    parameter int DW_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_busy,
    input  logic [2:0]        in_kind,
    input  logic              in_big_endian,
    input  logic [REG_W-1:0]  in_rt,
    input  logic [REG_W-1:0]  in_ra,
    input  logic [REG_W-1:0]  in_rb,
    input  logic [ADDR_W-1:0] in_ea,
    output logic              out_valid,
    input  logic              out_busy,
    output logic [REG_W-1:0]  out_reg,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_repeat,
    output logic              out_second,
    output logic              out_irq_hold,
    output logic              out_illegal,
    output logic              out_align_fault
);
    localparam int QW_BYTES   = 2 * DW_BYTES;
    localparam int ALIGN_BITS = $clog2(QW_BYTES);

    qstate_e           state_q, state_d;
    logic [2:0]        hold_kind;
    logic              hold_be;
    logic [REG_W-1:0]  hold_rt, hold_ra, hold_rb;
    logic [ADDR_W-1:0] hold_ea;
    logic              accept;
    logic              in_pair;
    logic              show_second;
    logic              chk_illegal, chk_align;

    assign in_pair     = kind_is_pair(in_kind);
    assign accept      = in_valid && !in_busy;
    assign show_second = (state_q == ST_SECOND);

    // state register and instruction holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_EMPTY;
            hold_kind <= QK_PLAIN;
            hold_be   <= 1'b0;
            hold_rt   <= '0;
            hold_ra   <= '0;
            hold_rb   <= '0;
            hold_ea   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                hold_kind <= in_kind;
                hold_be   <= in_big_endian;
                hold_rt   <= in_rt;
                hold_ra   <= in_ra;
                hold_rb   <= in_rb;
                hold_ea   <= in_ea;
            end
        end
    end

    // transitions: accept, advance, retire, chain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (in_valid) state_d = in_pair ? ST_FIRST : ST_SINGLE;
            end
            ST_FIRST: begin
                if (!out_busy) state_d = ST_SECOND;
            end
            ST_SINGLE, ST_SECOND: begin
                if (!out_busy) begin
                    if (in_valid) state_d = in_pair ? ST_FIRST : ST_SINGLE;
                    else          state_d = ST_EMPTY;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        out_valid    = 1'b0;
        out_repeat   = 1'b0;
        out_second   = 1'b0;
        out_irq_hold = 1'b0;
        in_busy      = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_busy = 1'b0;
            end
            ST_SINGLE: begin
                out_valid = 1'b1;
                in_busy   = out_busy;
            end
            ST_FIRST: begin
                out_valid  = 1'b1;
                out_repeat = 1'b1;
                in_busy    = 1'b1;
            end
            ST_SECOND: begin
                out_valid    = 1'b1;
                out_repeat   = 1'b1;
                out_second   = 1'b1;
                out_irq_hold = 1'b1;
                in_busy      = out_busy;
            end
            default: in_busy = 1'b0;
        endcase
        out_illegal     = out_valid && chk_illegal;
        out_align_fault = out_valid && chk_align;
    end

    qd_regsel #(.REG_W(REG_W)) u_regsel (
        .is_pair    (kind_is_pair(hold_kind)),
        .big_endian (hold_be),
        .second     (show_second),
        .rt         (hold_rt),
        .reg_out    (out_reg)
    );

    qd_addrstep #(.ADDR_W(ADDR_W), .DW_BYTES(DW_BYTES)) u_addrstep (
        .base   (hold_ea),
        .second (show_second),
        .addr   (out_addr)
    );

    qd_legality #(.REG_W(REG_W), .QW_BYTES(QW_BYTES), .ALIGN_BITS(ALIGN_BITS)) u_legality (
        .kind        (hold_kind),
        .big_endian  (hold_be),
        .rt          (hold_rt),
        .ra          (hold_ra),
        .rb          (hold_rb),
        .ea_lo       (hold_ea[ALIGN_BITS-1:0]),
        .illegal     (chk_illegal),
        .align_fault (chk_align)
    );

    // R10
    first_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_repeat && !out_second) |-> in_busy);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_busy) |=> (out_valid && $stable(out_reg) &&
                                     $stable(out_addr) && $stable(out_second)));

    // R4
    second_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_busy && out_repeat && !out_second) |=> (out_valid && out_second && out_repeat));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_busy && out_repeat && !out_second) |=>
        (out_addr == $past(out_addr) + ADDR_W'(DW_BYTES)));

    // R2
    pair_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_busy && out_repeat && !out_second) |=>
        (out_reg == ($past(out_reg) ^ REG_W'(1))));

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_irq_hold |-> (out_valid && out_second));

endmodule

// File: tb/qd_doubler_bench.sv
`timescale 1ns/1ps
module qd_doubler_bench;

    typedef struct packed {
        logic [2:0]  kind;
        logic        be;
        logic [4:0]  rt;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [63:0] ea;
        logic [4:0]  r1;
        logic [4:0]  r2;
        logic        ill;
        logic        al;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 1'b0, 5'd6,  5'd3,  5'd0, 64'h1000, 5'd7,  5'd6,  1'b0, 1'b0},
        '{3'd1, 1'b1, 5'd6,  5'd3,  5'd0, 64'h1008, 5'd6,  5'd7,  1'b0, 1'b0},
        '{3'd2, 1'b0, 5'd10, 5'd10, 5'd0, 64'h2008, 5'd11, 5'd10, 1'b0, 1'b0},
        '{3'd2, 1'b1, 5'd10, 5'd1,  5'd0, 64'h2000, 5'd10, 5'd11, 1'b0, 1'b0},
        '{3'd3, 1'b0, 5'd4,  5'd4,  5'd1, 64'h3000, 5'd5,  5'd4,  1'b1, 1'b0},
        '{3'd3, 1'b1, 5'd4,  5'd2,  5'd4, 64'h3010, 5'd4,  5'd5,  1'b1, 1'b0},
        '{3'd4, 1'b0, 5'd8,  5'd8,  5'd8, 64'h4000, 5'd9,  5'd8,  1'b0, 1'b0},
        '{3'd1, 1'b0, 5'd12, 5'd12, 5'd0, 64'h5004, 5'd13, 5'd12, 1'b1, 1'b1},
        '{3'd3, 1'b0, 5'd2,  5'd3,  5'd5, 64'h6001, 5'd3,  5'd2,  1'b0, 1'b1},
        '{3'd0, 1'b0, 5'd9,  5'd9,  5'd9, 64'h7000, 5'd9,  5'd9,  1'b0, 1'b0},
        '{3'd1, 1'b1, 5'd7,  5'd1,  5'd0, 64'h0010, 5'd6,  5'd7,  1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_busy;
    logic [2:0]  in_kind = '0;
    logic        in_big_endian = 1'b0;
    logic [4:0]  in_rt = '0, in_ra = '0, in_rb = '0;
    logic [63:0] in_ea = '0;
    logic        out_valid;
    logic        out_busy = 1'b0;
    logic [4:0]  out_reg;
    logic [63:0] out_addr;
    logic        out_repeat, out_second, out_irq_hold, out_illegal, out_align_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    qd_doubler u_qd_doubler (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_busy(in_busy), .in_kind(in_kind),
        .in_big_endian(in_big_endian), .in_rt(in_rt), .in_ra(in_ra), .in_rb(in_rb),
        .in_ea(in_ea), .out_valid(out_valid), .out_busy(out_busy),
        .out_reg(out_reg), .out_addr(out_addr), .out_repeat(out_repeat),
        .out_second(out_second), .out_irq_hold(out_irq_hold),
        .out_illegal(out_illegal), .out_align_fault(out_align_fault)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_kind       = v.kind;
        in_big_endian = v.be;
        in_rt         = v.rt;
        in_ra         = v.ra;
        in_rb         = v.rb;
        in_ea         = v.ea;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 out_valid", out_valid, 0);
        chk("R11 in_busy", in_busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after reset", out_valid, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic pair;
            v = VECS[i];
            pair = (v.kind >= 3'd1) && (v.kind <= 3'd4);
            drive(v);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            chk("R1 first valid", out_valid, 1);
            chk(v.be ? "R3 first reg" : "R2 first reg", out_reg, v.r1);
            chk("R5 first addr", out_addr, v.ea);
            chk("R4 first repeat", out_repeat, pair);
            chk("R4 first second", out_second, 0);
            chk("R9 hold off on first", out_irq_hold, 0);
            chk((v.kind == 3'd3) ? "R7 illegal" : "R6 illegal", out_illegal, v.ill);
            chk("R8 align", out_align_fault, v.al);
            if (pair) begin
                chk("R10 busy on first", in_busy, 1);
                @(negedge clk);
                chk("R1 second valid", out_valid, 1);
                chk(v.be ? "R3 second reg" : "R2 second reg", out_reg, v.r2);
                chk("R5 second addr", out_addr, v.ea + 64'd8);
                chk("R4 second repeat", out_repeat, 1);
                chk("R4 second flag", out_second, 1);
                chk("R9 hold on second", out_irq_hold, 1);
                chk("R7 illegal second", out_illegal, v.ill);
                chk("R8 align second", out_align_fault, v.al);
            end
            @(negedge clk);
            chk("R1 op count done", out_valid, 0);
        end

        // R10 stall on the first op, new instruction must wait
        out_busy = 1'b1;
        drive('{3'd1, 1'b0, 5'd20, 5'd1, 5'd0, 64'h8000, 5'd21, 5'd20, 1'b0, 1'b0});
        in_valid = 1'b1;
        @(negedge clk);
        drive('{3'd0, 1'b0, 5'd30, 5'd1, 5'd0, 64'h9000, 5'd30, 5'd30, 1'b0, 1'b0});
        for (int k = 0; k < 3; k++) begin
            chk("R10 busy while first", in_busy, 1);
            chk("R10 frozen reg", out_reg, 21);
            chk("R10 frozen addr", out_addr, 64'h8000);
            chk("R10 frozen second", out_second, 0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        out_busy = 1'b0;
        @(negedge clk);
        chk("R10 second after release", out_second, 1);
        chk("R2 second reg after stall", out_reg, 20);
        @(negedge clk);
        chk("R1 no extra op", out_valid, 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule